// File: doc/BRIEF.md
# Page Write Collector and Self-Timed Commit Sequencer

This block sits behind the byte engine of a two-wire serial memory slave. Data bytes of a write transaction reach it over a valid/ready stream. The first accepted byte of a transaction latches a base address. That address is split into a fixed page number and a four-bit offset inside the page. Each later byte lands at the next offset, and the offset wraps within the page. A per-offset valid mask records which locations this transaction has touched.

When the bus master ends the transaction with a STOP, the block starts a self-timed commit. The busy flag rises, and during the first cycles of busy the block emits one array write strobe for each marked offset, in ascending offset order. Busy is held for a programmable number of clocks that models the cell programming time.

A repeated START before STOP (the abort strobe) throws the collected page away. The hardware write-protect input, when high at STOP, also discards the page and starts no write cycle. The slave engine uses busy to withhold its acknowledges.

The byte stream follows these back-pressure rules:
- A byte transfers on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is low while busy, and also in any cycle where the stop or abort strobe is high.
- A byte offered while `in_ready` is low is not taken. The producer must hold it, or drop it as the slave engine decides.

Top module: `pgw_seq`

## Requirements
- R1: After reset `busy` and `mem_we` are 0 and no bytes are pending. `in_ready` equals `!busy && !stop_i && !abort_i`, and a byte is accepted only on an edge where `in_valid && in_ready`.
- R2: The first accepted byte of a transaction takes `base_addr[10:4]` as the page and `base_addr[3:0]` as the offset. Each accepted byte is stored at the current offset. The offset then increments modulo 16 while the page stays fixed, and later `base_addr` values are ignored.
- R3: When more than 16 bytes arrive before STOP, later bytes overwrite earlier ones at the wrapped offsets, so each offset holds the last byte written to it.
- R4: A `stop_i` pulse sampled while idle, with at least one byte pending and `wp_i` low, raises `busy` on the next edge. `busy` then stays high for exactly WRITE_CYCLES clock cycles.
- R5: During a commit, `mem_we` pulses only while `busy` is high. It pulses once per written offset, in strictly ascending address order, with `mem_addr = {page, offset}` and `mem_wdata` equal to the stored byte.
- R6: Array locations of the page that were not written in the transaction receive no write strobe and keep their contents.
- R7: A `stop_i` pulse with no pending byte starts no write cycle, and `busy` stays 0.
- R8: A `stop_i` pulse with `wp_i` high starts no write cycle, produces no `mem_we`, and discards the pending bytes.
- R9: An `abort_i` pulse while idle discards the pending bytes. A later STOP then commits nothing, and the next byte starts a new transaction with a fresh base address.
- R10: While busy, `stop_i` and `abort_i` are ignored, so the cycle length and the written data are unchanged, and `in_ready` is 0.
- R11: A single-byte transaction follows the same path and produces exactly one `mem_we` at its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Data byte offered |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | 8 | Data byte |
| base_addr | input | 11 | Start address, used on the first byte of a transaction |
| stop_i | input | 1 | One-cycle STOP strobe |
| abort_i | input | 1 | One-cycle repeated-START strobe, cancels the pending page |
| wp_i | input | 1 | Write protect, sampled with STOP |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 11 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
The hardest case to reach from the ports is a STOP or abort arriving in the middle of a running commit. The same applies to a byte offered at that moment, which must be refused without disturbing the scan or the cycle length. Directed tests pulse STOP and offer a byte a few cycles into busy, then check the busy length, the write count and the page contents. Seeded random transactions cover page wrap with more than 16 bytes, gaps left in the page, aborts and write protect. Each is checked against a byte-level array model kept in the bench.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int unsigned PGW_DATA_W = 8;
  localparam int unsigned PGW_ADDR_W = 11;
  localparam int unsigned PGW_PAGE_BYTES = 16;
endpackage

// File: rtl/pgw_latch.sv
module pgw_latch #(
  parameter int unsigned DATA_W = pgw_pkg::PGW_DATA_W,
  parameter int unsigned ADDR_W = pgw_pkg::PGW_ADDR_W,
  parameter int unsigned PAGE_BYTES = pgw_pkg::PGW_PAGE_BYTES,
  localparam int unsigned IDX_W = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W = ADDR_W - IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc,
  input  logic [DATA_W-1:0]     data,
  input  logic [ADDR_W-1:0]     base,
  input  logic                  clear,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [PAGE_BYTES-1:0] mask,
  output logic [PAGE_W-1:0]     page,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  any
);
  logic [IDX_W-1:0]  ptr_q;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] slot [PAGE_BYTES];

  assign any    = |mask;
  assign wr_idx = any ? ptr_q : base[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask  <= '0;
      ptr_q <= '0;
      page  <= '0;
    end else if (clear) begin
      mask <= '0;
    end else if (acc) begin
      mask[wr_idx] <= 1'b1;
      ptr_q        <= wr_idx + IDX_W'(1);
      if (!any) page <= base[ADDR_W-1:IDX_W];
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (acc && wr_idx == IDX_W'(g)) slot[g] <= data;
    end
  end

  assign rd_data = slot[rd_idx];

  assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !clear && any) |=> (ptr_q == $past(ptr_q) + IDX_W'(1)));
  assert_abort_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (mask == '0));
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
  parameter int unsigned PAGE_BYTES = pgw_pkg::PGW_PAGE_BYTES,
  parameter int unsigned WRITE_CYCLES = 1000000,
  localparam int unsigned IDX_W = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W = $clog2(WRITE_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             scan_act,
  output logic [IDX_W-1:0] scan_idx,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(PAGE_BYTES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end
    end else if (cnt_q == LAST) begin
      busy <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign scan_act = busy && (cnt_q < SCAN_END);
  assign scan_idx = cnt_q[IDX_W-1:0];
  assign done     = busy && (cnt_q == LAST);

  assert_start_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_done_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq #(
  parameter int unsigned DATA_W = pgw_pkg::PGW_DATA_W,
  parameter int unsigned ADDR_W = pgw_pkg::PGW_ADDR_W,
  parameter int unsigned PAGE_BYTES = pgw_pkg::PGW_PAGE_BYTES,
  parameter int unsigned WRITE_CYCLES = 1000000,
  localparam int unsigned IDX_W = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              stop_i,
  input  logic              abort_i,
  input  logic              wp_i,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy
);
  logic                  acc, clear, start, done, any, scan_act;
  logic [PAGE_BYTES-1:0] mask;
  logic [PAGE_W-1:0]     page;
  logic [IDX_W-1:0]      scan_idx;
  logic [DATA_W-1:0]     rd_data;

  assign in_ready = !busy && !stop_i && !abort_i;
  assign acc      = in_valid && in_ready;
  assign start    = !busy && stop_i && !abort_i && any && !wp_i;
  assign clear    = done || (!busy && (abort_i || (stop_i && (wp_i || !any))));

  pgw_latch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) latch_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .data(in_data), .base(base_addr),
    .clear(clear), .rd_idx(scan_idx), .mask(mask), .page(page),
    .rd_data(rd_data), .any(any)
  );

  pgw_timer #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .scan_act(scan_act), .scan_idx(scan_idx), .done(done)
  );

  assign mem_we    = scan_act && mask[scan_idx];
  assign mem_addr  = {page, scan_idx};
  assign mem_wdata = rd_data;

  assert_we_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  assert_no_take_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  assert_wp_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_i && wp_i) |=> !busy);
  assert_empty_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_i && !any) |=> !busy);
  assert_page_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(page));
endmodule

// File: tb/pgw_seq_tb.sv
module pgw_seq_tb_top;
  localparam int WCYC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic [10:0] base_addr = '0;
  logic stop_i = 1'b0, abort_i = 1'b0, wp_i = 1'b0;
  logic mem_we, busy;
  logic [10:0] mem_addr;
  logic [7:0] mem_wdata;

  always #2.5 clk = ~clk;

  pgw_seq #(.WRITE_CYCLES(WCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .base_addr(base_addr), .stop_i(stop_i), .abort_i(abort_i),
    .wp_i(wp_i), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy)
  );

  int checks = 0, fails = 0;
  logic [7:0] obs_mem [2048];
  logic [7:0] exp_mem [2048];
  int wr_cnt = 0;
  logic order_bad = 1'b0;
  logic [10:0] last_wa = '0;

  logic [7:0] pend_data [16];
  logic [15:0] pend_mask = '0;
  logic [6:0] pend_page = '0;
  logic [3:0] pend_ptr = '0;

  always @(negedge clk) begin
    if (mem_we) begin
      if (wr_cnt > 0 && mem_addr <= last_wa) order_bad = 1'b1;
      obs_mem[mem_addr] = mem_wdata;
      last_wa = mem_addr;
      wr_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] m);
    int n = 0;
    for (int i = 0; i < 16; i++) n += m[i];
    return n;
  endfunction

  task automatic m_byte(input logic [10:0] a, input logic [7:0] d);
    if (pend_mask == '0) begin
      pend_page = a[10:4];
      pend_ptr = a[3:0];
    end
    pend_data[pend_ptr] = d;
    pend_mask[pend_ptr] = 1'b1;
    pend_ptr = pend_ptr + 4'd1;
  endtask

  task automatic put_byte(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; base_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    m_byte(a, d);
  endtask

  task automatic do_abort();
    @(negedge clk); abort_i = 1'b1;
    @(negedge clk); abort_i = 1'b0;
    pend_mask = '0;
  endtask

  // Pulses STOP and checks busy length, write count, order and page contents.
  task automatic do_stop(input logic wp, input bit disturb, input string req);
    bit commit;
    int exp_w, nb;
    logic [6:0] pg;
    bit page_ok;
    commit = (pend_mask != '0) && !wp;
    exp_w = commit ? popc(pend_mask) : 0;
    pg = pend_page;
    if (commit)
      for (int i = 0; i < 16; i++)
        if (pend_mask[i]) exp_mem[{pend_page, 4'(i)}] = pend_data[i];
    wr_cnt = 0; order_bad = 1'b0;
    @(negedge clk); stop_i = 1'b1; wp_i = wp;
    @(negedge clk); stop_i = 1'b0; wp_i = 1'b0;
    nb = 0;
    for (int c = 0; c < WCYC + 8; c++) begin
      if (busy) nb++;
      if (disturb && c == 3) begin
        stop_i = 1'b1; abort_i = 1'b1; in_valid = 1'b1; in_data = 8'hEE;
        #1;
        chk(in_ready == 1'b0, "R10", "in_ready during busy", int'(in_ready), 0);
      end else if (disturb && c == 4) begin
        stop_i = 1'b0; abort_i = 1'b0; in_valid = 1'b0;
      end
      @(negedge clk);
    end
    pend_mask = '0;
    chk(nb == (commit ? WCYC : 0), req, "busy cycles", nb, commit ? WCYC : 0);
    chk(wr_cnt == exp_w, req, "write strobes", wr_cnt, exp_w);
    chk(!order_bad, "R5", "ascending write order", int'(order_bad), 0);
    page_ok = 1'b1;
    for (int i = 0; i < 16; i++)
      if (obs_mem[{pg, 4'(i)}] !== exp_mem[{pg, 4'(i)}]) page_ok = 1'b0;
    chk(page_ok, req, "page contents match model (R6)", int'(page_ok), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin obs_mem[i] = '0; exp_mem[i] = '0; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(mem_we == 1'b0, "R1", "mem_we after reset", int'(mem_we), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    // R1 stop strobe removes ready
    stop_i = 1'b1; #1;
    chk(in_ready == 1'b0, "R1", "in_ready with stop", int'(in_ready), 0);
    stop_i = 1'b0;
    @(negedge clk);

    // R7 stop with nothing pending
    do_stop(1'b0, 1'b0, "R7");

    // R11 single byte write
    put_byte(11'h123, 8'h5A);
    do_stop(1'b0, 1'b0, "R11");

    // R2 / R6 partial page at offset 5, later base_addr ignored
    put_byte(11'h245, 8'h11);
    put_byte(11'h7FF, 8'h22);
    put_byte(11'h000, 8'h33);
    do_stop(1'b0, 1'b0, "R2");

    // R3 twenty bytes from offset 12, wrap overwrites
    for (int i = 0; i < 20; i++) put_byte(11'h3AC, 8'(8'h80 + i));
    do_stop(1'b0, 1'b0, "R3");

    // R8 write protect discards
    put_byte(11'h245, 8'hF0);
    put_byte(11'h245, 8'hF1);
    do_stop(1'b1, 1'b0, "R8");
    // after WP discard, a new byte uses a fresh base
    put_byte(11'h502, 8'h77);
    do_stop(1'b0, 1'b0, "R8");

    // R9 abort discards, then fresh transaction
    put_byte(11'h610, 8'hAB);
    do_abort();
    do_stop(1'b0, 1'b0, "R9");
    put_byte(11'h61F, 8'hCD);
    do_stop(1'b0, 1'b0, "R9");

    // R10 stop/abort/byte during busy ignored
    put_byte(11'h4A0, 8'h01);
    put_byte(11'h4A0, 8'h02);
    do_stop(1'b0, 1'b1, "R10");

    // R4 random transactions
    for (int t = 0; t < 25; t++) begin
      int nbytes;
      logic [10:0] a;
      nbytes = $urandom_range(1, 24);
      a = 11'($urandom);
      for (int k = 0; k < nbytes; k++) put_byte(a, 8'($urandom));
      if ($urandom_range(0, 4) == 0) do_abort();
      do_stop(($urandom_range(0, 5) == 0), 1'b0, "R4");
    end

    begin
      bit all_ok = 1'b1;
      for (int i = 0; i < 2048; i++) if (obs_mem[i] !== exp_mem[i]) all_ok = 1'b0;
      chk(all_ok, "R6", "whole array matches model", int'(all_ok), 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule